// File: doc/BRIEF.md
# Secure Boot Mode Sequencer

This block decides how the chip comes out of reset. While reset is held it samples a test-enable pin and loads a fixed control word into the control register. After reset it captures a second test pin and a 2-bit function select through a synchronizer, exactly once. With the test pin low it reads a security key word from flash. A matching key launches the application. A missing key unlocks the debug port, and the sequencer then parks for good so that the debug access port can be reached.

With the test pin high, the select value picks one service function. The functions are a flash erase that repeats until a full blank scan passes, a self-test that never ends, a report of two identity words, and a wrapping sum over the whole flash. Results leave as single-cycle report strobes carrying a code and a data word. A separate reporter formats them for a serial port.

The block uses a flash model through a one-outstanding read port and an erase request/done pair. It never services a watchdog, including while parked.

Top module: `boot_mode_seq`

## Requirements
- R1: While `rstN` is low, `ctrlWord` loads `BOOT_CW` (default 16'h0001; bit 0 selects boot-ROM execution, bit 1 is the debug enable and is 0) if `testEnPin` is high, and loads 0 otherwise. With a 0 control word the sequencer raises `appStart` with no flash read or erase.
- R2: `testPin` and `funcSel` pass through a two-flop synchronizer and are captured once, on the first clock after reset release. Later changes on them have no effect on the outcome.
- R3: With the captured test pin low, one read is made at `SV_ADDR` (default 62). If the word equals `SV_KEY`, `appStart` goes high and stays high, and `dbgEnable` stays low.
- R4: With the test pin low and a key mismatch, `dbgEnable` goes high and stays high. No further flash read or erase request follows.
- R5: Select 0 scans flash addresses upward from 0. A word is blank when all its bits are one. On the first non-blank word the scan stops, one erase is requested, and after `flashEraseDone` the scan restarts from address 0.
- R6: When a scan reaches the last address with every word blank, exactly one report with code 1 is sent, and the sequencer then issues no more requests.
- R7: Select 1 raises `selfTestBusy` permanently, with no reports and no flash reads.
- R8: Select 2 reads `ID_ADDR` (default 60) and then `ID_ADDR+1`. It reports code 2 with the first word, then code 3 with the second word.
- R9: Select 3 reads every address in ascending order. It reports code 4 with the sum of all words modulo 2^DATA_W.
- R10: No erase request and no service function runs unless the captured test pin is high.
- R11: `appStart` and `dbgEnable` are never high together, and each stays high once raised. During reset all request, strobe and outcome outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| testEnPin | input | 1 | Test enable, sampled while reset is held |
| testPin | input | 1 | Service test pin, captured after reset |
| funcSel | input | 2 | Service function select |
| flashRdReq | output | 1 | One-cycle read request |
| flashAddr | output | ADDR_W | Flash word address |
| flashRdData | input | DATA_W | Read data |
| flashRdValid | input | 1 | Read data valid |
| flashEraseReq | output | 1 | One-cycle full erase request |
| flashEraseDone | input | 1 | Erase complete pulse |
| ctrlWord | output | CW_W | Control register |
| appStart | output | 1 | Application launch |
| dbgEnable | output | 1 | Debug port unlocked, parked |
| selfTestBusy | output | 1 | Self-test running |
| rptValid | output | 1 | Report strobe |
| rptCode | output | 3 | Report code: 1 blank, 2 ROM id, 3 factory id, 4 sum |
| rptData | output | DATA_W | Report data word |

## Verification
The assertions check on every cycle that launch and debug unlock are exclusive and sticky, and that a parked sequencer stays silent on the flash port. They also check that an erase only follows a high captured test pin, that the control word stays fixed after reset, and that reads never overlap. Only the bench scenarios can show the end results: the outcome chosen for each key and pin combination, the restart of the scan after an erase that leaves a stuck word, the ascending read order, the report codes and data values, and the disregard of pin changes after capture.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

  localparam logic [2:0] RPT_NONE  = 3'd0;
  localparam logic [2:0] RPT_BLANK = 3'd1;
  localparam logic [2:0] RPT_ROMID = 3'd2;
  localparam logic [2:0] RPT_FACID = 3'd3;
  localparam logic [2:0] RPT_SUM   = 3'd4;

  localparam logic [1:0] FN_ERASE    = 2'd0;
  localparam logic [1:0] FN_SELFTEST = 2'd1;
  localparam logic [1:0] FN_IDS      = 2'd2;
  localparam logic [1:0] FN_SUM      = 2'd3;

  typedef struct packed {
    logic addrClr;
    logic addrInc;
    logic addrLdKey;
    logic addrLdId;
    logic accClr;
    logic accAdd;
    logic capMode;
    logic rptLoad;
    logic rptFromAcc;
  } seqStrobe_t;

  typedef struct packed {
    logic       bootRom;
    logic       testLat;
    logic [1:0] selLat;
    logic       wordBlank;
    logic       keyMatch;
    logic       addrLast;
  } seqStat_t;

endpackage

// File: rtl/boot_seq_dp.sv
module boot_seq_dp
  import boot_seq_pkg::*;
#(
  parameter int          ADDR_W  = 6,
  parameter int          DATA_W  = 32,
  parameter int          CW_W    = 16,
  parameter logic [15:0] BOOT_CW = 16'h0001,
  parameter int          SV_ADDR = 62,
  parameter int          ID_ADDR = 60,
  parameter logic [31:0] SV_KEY  = 32'h5A17_C3E9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              testEnPin,
  input  logic              testPin,
  input  logic [1:0]        funcSel,
  input  seqStrobe_t        stb,
  input  logic [DATA_W-1:0] flashRdData,
  output logic [ADDR_W-1:0] flashAddr,
  output logic [CW_W-1:0]   ctrlWord,
  output logic [DATA_W-1:0] rptData,
  output seqStat_t          stat
);

  localparam int SYNC_W = 3;
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'((1 << ADDR_W) - 1);
  localparam logic [ADDR_W-1:0] KEY_ADDR  = ADDR_W'(SV_ADDR);
  localparam logic [ADDR_W-1:0] IDW_ADDR  = ADDR_W'(ID_ADDR);
  localparam logic [CW_W-1:0]   CW_BOOT   = CW_W'(BOOT_CW);
  localparam logic [DATA_W-1:0] KEY_VAL   = DATA_W'(SV_KEY);

  // two-flop synchronizer, free running through reset
  logic [SYNC_W-1:0] syncA, syncB;
  always_ff @(posedge clk) begin
    syncA <= {testPin, funcSel};
    syncB <= syncA;
  end

  // control register: loaded only while reset is held
  always_ff @(posedge clk) begin
    if (!rstN) ctrlWord <= testEnPin ? CW_BOOT : '0;
  end

  logic       modeTest;
  logic [1:0] modeSel;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeTest <= 1'b0;
      modeSel  <= 2'd0;
    end else if (stb.capMode) begin
      modeTest <= syncB[2];
      modeSel  <= syncB[1:0];
    end
  end

  logic [ADDR_W-1:0] addrQ;
  always_ff @(posedge clk) begin
    if (!rstN)              addrQ <= '0;
    else if (stb.addrClr)   addrQ <= '0;
    else if (stb.addrLdKey) addrQ <= KEY_ADDR;
    else if (stb.addrLdId)  addrQ <= IDW_ADDR;
    else if (stb.addrInc)   addrQ <= addrQ + 1'b1;
  end
  assign flashAddr = addrQ;

  logic [DATA_W-1:0] accQ, rptHold;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ    <= '0;
      rptHold <= '0;
    end else begin
      if (stb.accClr)      accQ <= '0;
      else if (stb.accAdd) accQ <= accQ + flashRdData;
      if (stb.rptLoad)     rptHold <= flashRdData;
    end
  end
  assign rptData = stb.rptFromAcc ? accQ : rptHold;

  always_comb begin
    stat.bootRom   = ctrlWord[0];
    stat.testLat   = modeTest;
    stat.selLat    = modeSel;
    stat.wordBlank = &flashRdData;
    stat.keyMatch  = (flashRdData == KEY_VAL);
    stat.addrLast  = (addrQ == LAST_ADDR);
  end

  // R1: control word fixed once reset is released
  a_r1_cw_hold: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> $stable(ctrlWord));

  // R2: captured mode only changes on the single capture strobe
  a_r2_mode_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.capMode && !$rose(rstN)) |=> $stable({modeTest, modeSel}));

endmodule

// File: rtl/boot_seq_ctrl.sv
module boot_seq_ctrl
  import boot_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  seqStat_t   stat,
  input  logic       flashRdValid,
  input  logic       flashEraseDone,
  output seqStrobe_t stb,
  output logic       flashRdReq,
  output logic       flashEraseReq,
  output logic       appStart,
  output logic       dbgEnable,
  output logic       selfTestBusy,
  output logic       rptValid,
  output logic [2:0] rptCode
);

  typedef enum logic [4:0] {
    ST_SAMPLE, ST_DECIDE, ST_KEY_RD, ST_KEY_WAIT, ST_APP, ST_PARK,
    ST_BLK_RD, ST_BLK_WAIT, ST_ERASE, ST_ERASE_WAIT, ST_RPT_BLANK,
    ST_SELFTEST, ST_ID_RD, ST_ID_WAIT, ST_RPT_ROM, ST_FAC_RD,
    ST_FAC_WAIT, ST_RPT_FAC, ST_SUM_RD, ST_SUM_WAIT, ST_RPT_SUM, ST_DONE
  } seqState_e;

  seqState_e state, stateNxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_SAMPLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    stb      = '0;
    unique case (state)
      ST_SAMPLE: begin
        stb.capMode = 1'b1;
        stateNxt    = stat.bootRom ? ST_DECIDE : ST_APP;
      end
      ST_DECIDE: begin
        if (!stat.testLat) begin
          stb.addrLdKey = 1'b1;
          stateNxt      = ST_KEY_RD;
        end else begin
          unique case (stat.selLat)
            FN_ERASE: begin
              stb.addrClr = 1'b1;
              stateNxt    = ST_BLK_RD;
            end
            FN_SELFTEST: stateNxt = ST_SELFTEST;
            FN_IDS: begin
              stb.addrLdId = 1'b1;
              stateNxt     = ST_ID_RD;
            end
            FN_SUM: begin
              stb.addrClr = 1'b1;
              stb.accClr  = 1'b1;
              stateNxt    = ST_SUM_RD;
            end
            default: stateNxt = ST_DONE;
          endcase
        end
      end
      ST_KEY_RD: stateNxt = ST_KEY_WAIT;
      ST_KEY_WAIT: if (flashRdValid) stateNxt = stat.keyMatch ? ST_APP : ST_PARK;
      ST_BLK_RD: stateNxt = ST_BLK_WAIT;
      ST_BLK_WAIT: begin
        if (flashRdValid) begin
          if (!stat.wordBlank) stateNxt = ST_ERASE;
          else if (stat.addrLast) stateNxt = ST_RPT_BLANK;
          else begin
            stb.addrInc = 1'b1;
            stateNxt    = ST_BLK_RD;
          end
        end
      end
      ST_ERASE: stateNxt = ST_ERASE_WAIT;
      ST_ERASE_WAIT: begin
        if (flashEraseDone) begin
          stb.addrClr = 1'b1;
          stateNxt    = ST_BLK_RD;
        end
      end
      ST_RPT_BLANK: stateNxt = ST_DONE;
      ST_ID_RD: stateNxt = ST_ID_WAIT;
      ST_ID_WAIT: begin
        if (flashRdValid) begin
          stb.rptLoad = 1'b1;
          stateNxt    = ST_RPT_ROM;
        end
      end
      ST_RPT_ROM: begin
        stb.addrInc = 1'b1;
        stateNxt    = ST_FAC_RD;
      end
      ST_FAC_RD: stateNxt = ST_FAC_WAIT;
      ST_FAC_WAIT: begin
        if (flashRdValid) begin
          stb.rptLoad = 1'b1;
          stateNxt    = ST_RPT_FAC;
        end
      end
      ST_RPT_FAC: stateNxt = ST_DONE;
      ST_SUM_RD: stateNxt = ST_SUM_WAIT;
      ST_SUM_WAIT: begin
        if (flashRdValid) begin
          stb.accAdd = 1'b1;
          if (stat.addrLast) stateNxt = ST_RPT_SUM;
          else begin
            stb.addrInc = 1'b1;
            stateNxt    = ST_SUM_RD;
          end
        end
      end
      ST_RPT_SUM: begin
        stb.rptFromAcc = 1'b1;
        stateNxt       = ST_DONE;
      end
      default: stateNxt = state;
    endcase
  end

  assign flashRdReq    = (state == ST_KEY_RD) || (state == ST_BLK_RD) || (state == ST_ID_RD) ||
                         (state == ST_FAC_RD) || (state == ST_SUM_RD);
  assign flashEraseReq = (state == ST_ERASE);
  assign appStart      = (state == ST_APP);
  assign dbgEnable     = (state == ST_PARK);
  assign selfTestBusy  = (state == ST_SELFTEST);
  assign rptValid      = (state == ST_RPT_BLANK) || (state == ST_RPT_ROM) ||
                         (state == ST_RPT_FAC) || (state == ST_RPT_SUM);

  always_comb begin
    unique case (state)
      ST_RPT_BLANK: rptCode = RPT_BLANK;
      ST_RPT_ROM:   rptCode = RPT_ROMID;
      ST_RPT_FAC:   rptCode = RPT_FACID;
      ST_RPT_SUM:   rptCode = RPT_SUM;
      default:      rptCode = RPT_NONE;
    endcase
  end

  // R11: outcomes exclusive and sticky
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(appStart && dbgEnable));
  a_r11_app_hold: assert property (@(posedge clk) disable iff (!rstN)
    appStart |=> appStart);
  // R4: parked sequencer stays parked and silent on the flash port
  a_r4_park_quiet: assert property (@(posedge clk) disable iff (!rstN)
    dbgEnable |=> (dbgEnable && !flashRdReq && !flashEraseReq));
  // R10: erase only after a high captured test pin
  a_r10_erase_gate: assert property (@(posedge clk) disable iff (!rstN)
    flashEraseReq |-> stat.testLat);
  // R1: zero control word never touches flash
  a_r1_no_flash: assert property (@(posedge clk) disable iff (!rstN)
    !stat.bootRom |-> (!flashRdReq && !flashEraseReq));
  // R7: self-test holds and stays silent
  a_r7_busy_hold: assert property (@(posedge clk) disable iff (!rstN)
    selfTestBusy |=> (selfTestBusy && !rptValid && !flashRdReq));
  // R5: one read outstanding at a time
  a_r5_single_read: assert property (@(posedge clk) disable iff (!rstN)
    flashRdReq |=> !flashRdReq);

endmodule

// File: rtl/boot_mode_seq.sv
module boot_mode_seq
  import boot_seq_pkg::*;
#(
  parameter int          ADDR_W  = 6,
  parameter int          DATA_W  = 32,
  parameter int          CW_W    = 16,
  parameter logic [15:0] BOOT_CW = 16'h0001,
  parameter int          SV_ADDR = 62,
  parameter int          ID_ADDR = 60,
  parameter logic [31:0] SV_KEY  = 32'h5A17_C3E9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              testEnPin,
  input  logic              testPin,
  input  logic [1:0]        funcSel,
  output logic              flashRdReq,
  output logic [ADDR_W-1:0] flashAddr,
  input  logic [DATA_W-1:0] flashRdData,
  input  logic              flashRdValid,
  output logic              flashEraseReq,
  input  logic              flashEraseDone,
  output logic [CW_W-1:0]   ctrlWord,
  output logic              appStart,
  output logic              dbgEnable,
  output logic              selfTestBusy,
  output logic              rptValid,
  output logic [2:0]        rptCode,
  output logic [DATA_W-1:0] rptData
);

  seqStrobe_t stb;
  seqStat_t   stat;

  boot_seq_ctrl u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .stat           (stat),
    .flashRdValid   (flashRdValid),
    .flashEraseDone (flashEraseDone),
    .stb            (stb),
    .flashRdReq     (flashRdReq),
    .flashEraseReq  (flashEraseReq),
    .appStart       (appStart),
    .dbgEnable      (dbgEnable),
    .selfTestBusy   (selfTestBusy),
    .rptValid       (rptValid),
    .rptCode        (rptCode)
  );

  boot_seq_dp #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .CW_W    (CW_W),
    .BOOT_CW (BOOT_CW),
    .SV_ADDR (SV_ADDR),
    .ID_ADDR (ID_ADDR),
    .SV_KEY  (SV_KEY)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .testEnPin   (testEnPin),
    .testPin     (testPin),
    .funcSel     (funcSel),
    .stb         (stb),
    .flashRdData (flashRdData),
    .flashAddr   (flashAddr),
    .ctrlWord    (ctrlWord),
    .rptData     (rptData),
    .stat        (stat)
  );

endmodule

// File: tb/boot_mode_seq_tb.sv
module boot_mode_seq_tb;

  localparam int          AW    = 6;
  localparam int          DW    = 32;
  localparam int          DEPTH = 1 << AW;
  localparam logic [31:0] KEY   = 32'h5A17_C3E9;
  localparam logic [15:0] BCW   = 16'h0001;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic testEnPin = 1'b0, testPin = 1'b0;
  logic [1:0] funcSel = 2'd0;
  logic flashRdReq, flashEraseReq, appStart, dbgEnable, selfTestBusy, rptValid;
  logic [AW-1:0] flashAddr;
  logic [DW-1:0] flashRdData = '0;
  logic flashRdValid = 1'b0, flashEraseDone = 1'b0;
  logic [15:0] ctrlWord;
  logic [2:0] rptCode;
  logic [DW-1:0] rptData;

  always #4 clk = ~clk;

  boot_mode_seq u_dut (
    .clk(clk), .rstN(rstN), .testEnPin(testEnPin), .testPin(testPin), .funcSel(funcSel),
    .flashRdReq(flashRdReq), .flashAddr(flashAddr), .flashRdData(flashRdData),
    .flashRdValid(flashRdValid), .flashEraseReq(flashEraseReq), .flashEraseDone(flashEraseDone),
    .ctrlWord(ctrlWord), .appStart(appStart), .dbgEnable(dbgEnable),
    .selfTestBusy(selfTestBusy), .rptValid(rptValid), .rptCode(rptCode), .rptData(rptData)
  );

  int total = 0, bad = 0;
  logic [DW-1:0] mem [DEPTH];
  int stickyAddr = -1, stickyLeft = 0, eraseTimer = 0;

  // behavioural flash
  always @(posedge clk) begin
    flashRdValid   <= flashRdReq;
    flashRdData    <= flashRdReq ? mem[flashAddr] : '0;
    flashEraseDone <= 1'b0;
    if (flashEraseReq) eraseTimer <= 5;
    else if (eraseTimer > 0) begin
      eraseTimer <= eraseTimer - 1;
      if (eraseTimer == 1) begin
        for (int i = 0; i < DEPTH; i++)
          if (!(i == stickyAddr && stickyLeft > 0)) mem[i] = '1;
        if (stickyLeft > 0) stickyLeft = stickyLeft - 1;
        flashEraseDone <= 1'b1;
      end
    end
  end

  // port monitors
  int readCnt, eraseCnt, rptCnt, orderErr, expNext;
  logic [2:0] rptCodes [4];
  logic [DW-1:0] rptDatas [4];
  always @(negedge clk) begin
    if (rstN) begin
      if (flashRdReq) begin
        if (int'(flashAddr) != expNext) orderErr++;
        expNext = int'(flashAddr) + 1;
        readCnt++;
      end
      if (flashEraseReq) begin
        eraseCnt++;
        expNext = 0;
      end
      if (rptValid) begin
        if (rptCnt < 4) begin
          rptCodes[rptCnt] = rptCode;
          rptDatas[rptCnt] = rptData;
        end
        rptCnt++;
      end
    end
  end

  task automatic check(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic startRun(logic te, logic tp, logic [1:0] sel, bit flip);
    @(negedge clk);
    rstN = 1'b0; testEnPin = te; testPin = tp; funcSel = sel;
    repeat (4) @(negedge clk);
    readCnt = 0; eraseCnt = 0; rptCnt = 0; orderErr = 0; expNext = 0;
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    if (flip) begin
      testPin = ~tp; funcSel = ~sel;
    end
  endtask

  task automatic fillMem(logic [DW-1:0] base, logic [DW-1:0] step);
    for (int i = 0; i < DEPTH; i++) mem[i] = base + step * DW'(i);
  endtask

  task automatic t_reset;
    @(negedge clk);
    rstN = 1'b0; testEnPin = 1'b1;
    repeat (3) @(negedge clk);
    check("R11", "reset outputs", {appStart, dbgEnable, flashRdReq, flashEraseReq, rptValid, selfTestBusy}, 0);
  endtask

  task automatic t_no_test_enable;
    fillMem(32'h1, 32'h3);
    startRun(1'b0, 1'b0, 2'd0, 1'b0);
    repeat (20) @(negedge clk);
    check("R1", "ctrlWord zero", ctrlWord, 0);
    check("R1", "appStart", appStart, 1);
    check("R1", "no flash access", readCnt + eraseCnt, 0);
  endtask

  task automatic t_key_ok;
    fillMem(32'h0, 32'h11);
    mem[62] = KEY;
    startRun(1'b1, 1'b0, 2'd0, 1'b0);
    repeat (30) @(negedge clk);
    check("R1", "ctrlWord boot", ctrlWord, BCW);
    check("R3", "appStart", appStart, 1);
    check("R3", "dbgEnable", dbgEnable, 0);
    check("R3", "single key read", readCnt, 1);
  endtask

  task automatic t_key_missing;
    fillMem(32'h0, 32'h11);
    mem[62] = KEY ^ 32'h1;
    startRun(1'b1, 1'b0, 2'd0, 1'b0);
    repeat (60) @(negedge clk);
    check("R4", "dbgEnable", dbgEnable, 1);
    check("R4", "appStart", appStart, 0);
    check("R4", "reads stay one", readCnt, 1);
    check("R10", "no erase with test low", eraseCnt, 0);
  endtask

  task automatic t_late_pins;
    fillMem(32'h0, 32'h11);
    mem[62] = KEY;
    startRun(1'b1, 1'b0, 2'd2, 1'b1);
    repeat (60) @(negedge clk);
    check("R2", "late pins ignored appStart", appStart, 1);
    check("R2", "late pins ignored busy", selfTestBusy, 0);
    check("R2", "late pins ignored reports", rptCnt, 0);
  endtask

  task automatic t_erase_retry;
    fillMem('1, 32'h0);
    mem[10] = 32'h0; mem[40] = 32'h1234;
    stickyAddr = 10; stickyLeft = 1;
    startRun(1'b1, 1'b1, 2'd0, 1'b1);
    repeat (500) @(negedge clk);
    check("R5", "erase count", eraseCnt, 2);
    check("R5", "reads", readCnt, 11 + 11 + DEPTH);
    check("R5", "ascending order", orderErr, 0);
    check("R6", "one report", rptCnt, 1);
    check("R6", "blank code", rptCodes[0], 1);
    stickyAddr = -1;
  endtask

  task automatic t_erase_clean;
    fillMem('1, 32'h0);
    startRun(1'b1, 1'b1, 2'd0, 1'b0);
    repeat (300) @(negedge clk);
    check("R5", "no erase when blank", eraseCnt, 0);
    check("R6", "single report", rptCnt, 1);
    check("R6", "quiet after report", readCnt, DEPTH);
  endtask

  task automatic t_selftest;
    startRun(1'b1, 1'b1, 2'd1, 1'b1);
    repeat (100) @(negedge clk);
    check("R7", "busy", selfTestBusy, 1);
    check("R7", "no reports", rptCnt, 0);
    check("R7", "no reads", readCnt, 0);
  endtask

  task automatic t_ids;
    fillMem(32'h100, 32'h7);
    mem[60] = 32'h56BC_78AB; mem[61] = 32'hDE9A_CDFE;
    startRun(1'b1, 1'b1, 2'd2, 1'b1);
    repeat (40) @(negedge clk);
    check("R8", "report count", rptCnt, 2);
    check("R8", "rom code", rptCodes[0], 2);
    check("R8", "rom data", rptDatas[0], 32'h56BC_78AB);
    check("R8", "fac code", rptCodes[1], 3);
    check("R8", "fac data", rptDatas[1], 32'hDE9A_CDFE);
  endtask

  task automatic t_sum;
    logic [DW-1:0] exp = '0;
    fillMem(32'hF000_0000, 32'h9E37_79B9);
    for (int i = 0; i < DEPTH; i++) exp = exp + mem[i];
    startRun(1'b1, 1'b1, 2'd3, 1'b0);
    repeat (300) @(negedge clk);
    check("R9", "reads", readCnt, DEPTH);
    check("R9", "ascending", orderErr, 0);
    check("R9", "report count", rptCnt, 1);
    check("R9", "sum code", rptCodes[0], 4);
    check("R9", "sum data", rptDatas[0], exp);
    check("R10", "no erase", eraseCnt, 0);
  endtask

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected<=150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    fillMem('1, 32'h0);
    t_reset();
    t_no_test_enable();
    t_key_ok();
    t_key_missing();
    t_late_pins();
    t_erase_retry();
    t_erase_clean();
    t_selftest();
    t_ids();
    t_sum();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule